// File: doc/BRIEF.md
# Real-Time Clock Control, Status and Interrupt Unit

This unit holds the two control/status bytes of a real-time clock and drives the clock's interrupt line. A host reads and writes the bytes over a plain synchronous register port: an address, a write strobe, write data, and combinational read data. The host bus bridge, the calendar counters and the alarm comparator sit outside. They reach this unit only as event pulses and as the one-second tick it produces.

The first byte holds a test-mode select, a power-on-reset override enable and a stop control. Stop holds the seconds prescaler at zero, so no one-second tick is produced. The oscillator-rate output keeps running while stop is set.

The second byte holds an alarm flag and a timer flag. Event pulses set the flags. Software clears a flag by writing a 0 to it; writing a 1 leaves the flag unchanged. The second byte also holds one interrupt enable per flag and a mode bit. The mode bit chooses whether the timer drives the interrupt as a level or as a fixed-width pulse. An enabled alarm always drives the interrupt as a level. The unit runs on a fast system clock, and `tick32k` qualifies each oscillator period.

Top module: `rtc_ctrl_status`

## Requirements
- R1: After reset, every register bit reads 0, `intN` is 1, `secTick` is 0, and `testMode` and `porOvr` are 0.
- R2: Address 00h holds the test-mode select at bit 7, stop at bit 5 and the reset-override enable at bit 3. Each bit is written by a write to 00h and reads back. Bit 7 drives `testMode` and bit 3 drives `porOvr`.
- R3: Reserved bits read 0 and ignore writes. These are bits 6, 4 and 2:0 of 00h and bits 7:5 of 01h. Any address other than 00h or 01h reads 0, and writes to it change nothing.
- R4: Address 01h holds the timer pulse-mode select at bit 4, the alarm interrupt enable at bit 1 and the timer interrupt enable at bit 0. Each bit is written by a write to 01h and reads back.
- R5: The alarm flag (01h bit 3) is set by `alarmEvt` and the timer flag (01h bit 2) is set by `timerEvt`. Each flag reads 1 from the clock edge that samples its event. A write to 01h with 0 at a flag's bit clears that flag. A write with 1 at that bit leaves the flag as it was.
- R6: If a flag's event and a clearing write are sampled on the same edge, the flag ends set.
- R7: With pulse mode at 0, `intN` is 0 exactly while the timer flag and the timer enable are both 1, unless R9 holds it low.
- R8: With pulse mode at 1 and the timer enable at 1, each `timerEvt` drives `intN` low for PULSE_LEN `tick32k` periods. The pulse starts at the edge that samples the event. A new event restarts the full width. With the timer enable at 0, the timer never pulls `intN` low.
- R9: While the alarm flag and the alarm enable are both 1, `intN` is 0 in either mode.
- R10: While not stopped, the prescaler counts `tick32k` and raises `secTick` on one of every 2^PRESC_W ticks.
- R11: While stop is 1, the prescaler is held at 0 and `secTick` stays 0. After stop is written to 0, the first `secTick` falls on the 2^PRESC_W-th `tick32k` that counts after the write edge.
- R12: `clkOut` follows `tick32k` whether or not stop is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register byte address |
| wrEn | input | 1 | Write strobe, one cycle per write |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr` (combinational) |
| tick32k | input | 1 | One-cycle enable per oscillator period |
| alarmEvt | input | 1 | Alarm match pulse, sets the alarm flag |
| timerEvt | input | 1 | Countdown expiry pulse, sets the timer flag |
| secTick | output | 1 | One-second tick enable |
| clkOut | output | 1 | Oscillator-rate enable, never stopped |
| testMode | output | 1 | Test-mode select |
| porOvr | output | 1 | Power-on-reset override enable |
| intN | output | 1 | Interrupt, active low |

## Verification
The bench writes and reads every byte value at both register addresses. A decoder that let reserved bits through would read back nonzero in those positions, and a flag that followed the written data would be set by writing a 1. The bench also sweeps all 32 combinations of mode, enables and flags. A design that let the pulse mode mask the alarm, or that let a stale timer flag pull the line low in pulse mode, would miscompare there.

Three timing cases are targeted separately:
- An event and a clearing write on the same edge. A design that lets the clear win loses the event.
- The exact width of the timer pulse, including a restart partway through.
- The tick count from the stop release to the first one-second tick. A prescaler that was not cleared, or that counted while stopped, would give the wrong count.

// File: rtl/rtc_cs_pkg.sv
package rtc_cs_pkg;

  localparam logic [7:0] ADDR_CTL1 = 8'h00;
  localparam logic [7:0] ADDR_CTL2 = 8'h01;

  // bit positions within the two bytes
  localparam int BIT_TEST  = 7;
  localparam int BIT_STOP  = 5;
  localparam int BIT_POR   = 3;
  localparam int BIT_MODE  = 4;
  localparam int BIT_AF    = 3;
  localparam int BIT_TF    = 2;
  localparam int BIT_AIE   = 1;
  localparam int BIT_TIE   = 0;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_CTL1 = 2'd1,
    RD_CTL2 = 2'd2
  } rdSel_t;

  typedef struct packed {
    logic wrCtl1;
    logic wrCtl2;
    logic clrAlarm;
    logic clrTimer;
  } csStrobe_t;

endpackage

// File: rtl/rtc_cs_ctrl.sv
module rtc_cs_ctrl
  import rtc_cs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] addr,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output csStrobe_t  stb,
  output rdSel_t     rdSel
);

  logic hitCtl1;
  logic hitCtl2;

  assign hitCtl1 = (addr == ADDR_CTL1);
  assign hitCtl2 = (addr == ADDR_CTL2);

  always_comb begin
    stb          = '0;
    stb.wrCtl1   = wrEn & hitCtl1;
    stb.wrCtl2   = wrEn & hitCtl2;
    stb.clrAlarm = wrEn & hitCtl2 & ~wrData[BIT_AF];
    stb.clrTimer = wrEn & hitCtl2 & ~wrData[BIT_TF];
  end

  always_comb begin
    if (hitCtl1)      rdSel = RD_CTL1;
    else if (hitCtl2) rdSel = RD_CTL2;
    else              rdSel = RD_NONE;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wrCtl1 && stb.wrCtl2)); // R3
  AST_CLR_NEEDS_WR: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrAlarm || stb.clrTimer) |-> stb.wrCtl2); // R5

endmodule

// File: rtl/rtc_cs_dp.sv
module rtc_cs_dp
  import rtc_cs_pkg::*;
#(
  parameter int PRESC_W   = 15,
  parameter int PULSE_LEN = 512
) (
  input  logic       clk,
  input  logic       rstN,
  input  csStrobe_t  stb,
  input  rdSel_t     rdSel,
  input  logic [7:0] wrData,
  input  logic       tick32k,
  input  logic       alarmEvt,
  input  logic       timerEvt,
  output logic [7:0] rdData,
  output logic       secTick,
  output logic       testMode,
  output logic       porOvr,
  output logic       intN
);

  localparam int PULSE_W = $clog2(PULSE_LEN + 1);
  localparam logic [PULSE_W-1:0] PULSE_LOAD = PULSE_W'(PULSE_LEN);
  localparam logic [PRESC_W-1:0] PRESC_TOP  = '1;

  logic testR, stopR, porR;
  logic modeR, afR, tfR, aieR, tieR;
  logic [PRESC_W-1:0] prescCnt;
  logic [PULSE_W-1:0] pulseCnt;
  logic pulseOn;
  logic timerTerm;

  // control/status bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      testR <= 1'b0; stopR <= 1'b0; porR <= 1'b0;
      modeR <= 1'b0; aieR  <= 1'b0; tieR <= 1'b0;
      afR   <= 1'b0; tfR   <= 1'b0;
    end else begin
      if (stb.wrCtl1) begin
        testR <= wrData[BIT_TEST];
        stopR <= wrData[BIT_STOP];
        porR  <= wrData[BIT_POR];
      end
      if (stb.wrCtl2) begin
        modeR <= wrData[BIT_MODE];
        aieR  <= wrData[BIT_AIE];
        tieR  <= wrData[BIT_TIE];
      end
      if (alarmEvt)          afR <= 1'b1;
      else if (stb.clrAlarm) afR <= 1'b0;
      if (timerEvt)          tfR <= 1'b1;
      else if (stb.clrTimer) tfR <= 1'b0;
    end
  end

  // seconds prescaler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        prescCnt <= '0;
    else if (stopR)   prescCnt <= '0;
    else if (tick32k) prescCnt <= prescCnt + 1'b1;
  end

  assign secTick = tick32k & ~stopR & (prescCnt == PRESC_TOP);

  // timer pulse stretcher
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       pulseCnt <= '0;
    else if (timerEvt)               pulseCnt <= PULSE_LOAD;
    else if (tick32k && pulseOn)     pulseCnt <= pulseCnt - 1'b1;
  end

  assign pulseOn   = (pulseCnt != '0);
  assign timerTerm = tieR & (modeR ? pulseOn : tfR);
  assign intN      = ~((afR & aieR) | timerTerm);

  assign testMode = testR;
  assign porOvr   = porR;

  always_comb begin
    rdData = 8'h00;
    unique case (rdSel)
      RD_CTL1: begin
        rdData[BIT_TEST] = testR;
        rdData[BIT_STOP] = stopR;
        rdData[BIT_POR]  = porR;
      end
      RD_CTL2: begin
        rdData[BIT_MODE] = modeR;
        rdData[BIT_AF]   = afR;
        rdData[BIT_TF]   = tfR;
        rdData[BIT_AIE]  = aieR;
        rdData[BIT_TIE]  = tieR;
      end
      default: rdData = 8'h00;
    endcase
  end

  AST_EVT_SETS_AF: assert property (@(posedge clk) disable iff (!rstN)
    alarmEvt |=> afR); // R6
  AST_EVT_SETS_TF: assert property (@(posedge clk) disable iff (!rstN)
    timerEvt |=> tfR); // R6
  AST_ONE_KEEPS_AF: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrCtl2 && !stb.clrAlarm && !alarmEvt) |=> (afR == $past(afR))); // R5
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    stopR |=> (prescCnt == '0)); // R11
  AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    stopR |-> !secTick); // R11
  AST_PULSE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt <= PULSE_LOAD); // R8
  AST_ALARM_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (afR && aieR && !stb.clrAlarm && !stb.wrCtl2) |=> !intN); // R9

endmodule

// File: rtl/rtc_ctrl_status.sv
module rtc_ctrl_status
  import rtc_cs_pkg::*;
#(
  parameter int PRESC_W   = 15,
  parameter int PULSE_LEN = 512
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] addr,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       tick32k,
  input  logic       alarmEvt,
  input  logic       timerEvt,
  output logic       secTick,
  output logic       clkOut,
  output logic       testMode,
  output logic       porOvr,
  output logic       intN
);

  csStrobe_t stb;
  rdSel_t    rdSel;

  rtc_cs_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .addr   (addr),
    .wrEn   (wrEn),
    .wrData (wrData),
    .stb    (stb),
    .rdSel  (rdSel)
  );

  rtc_cs_dp #(
    .PRESC_W   (PRESC_W),
    .PULSE_LEN (PULSE_LEN)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .rdSel    (rdSel),
    .wrData   (wrData),
    .tick32k  (tick32k),
    .alarmEvt (alarmEvt),
    .timerEvt (timerEvt),
    .rdData   (rdData),
    .secTick  (secTick),
    .testMode (testMode),
    .porOvr   (porOvr),
    .intN     (intN)
  );

  // the oscillator-rate output is never gated
  assign clkOut = tick32k;

  AST_RSVD_CTL1: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_CTL1) |-> ((rdData & 8'h57) == 8'h00)); // R3
  AST_RSVD_CTL2: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_CTL2) |-> ((rdData & 8'hE0) == 8'h00)); // R3

endmodule

// File: tb/test_rtc_ctrl_status.sv
module test_rtc_ctrl_status;

  localparam int PW = 4;
  localparam int PL = 5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       tick32k = 1'b0;
  logic       alarmEvt = 1'b0;
  logic       timerEvt = 1'b0;
  logic       secTick, clkOut, testMode, porOvr, intN;

  int nChk = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rtc_ctrl_status #(.PRESC_W(PW), .PULSE_LEN(PL)) i_rtc_ctrl_status (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .tick32k(tick32k), .alarmEvt(alarmEvt),
    .timerEvt(timerEvt), .secTick(secTick), .clkOut(clkOut),
    .testMode(testMode), .porOvr(porOvr), .intN(intN)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // write lands at the next posedge; returns at the following negedge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrData = 8'h00;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    addr = a;
    #1;
    check(tag, rdData, exp);
  endtask

  task automatic pulseAlarm();
    alarmEvt = 1'b1; @(negedge clk); alarmEvt = 1'b0;
  endtask

  task automatic pulseTimer();
    timerEvt = 1'b1; @(negedge clk); timerEvt = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  initial begin
    int first;
    int cnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h00, 8'h00, "R1 ctl1");
    rd(8'h01, 8'h00, "R1 ctl2");
    check("R1 intN", intN, 1);
    check("R1 secTick", secTick, 0);
    check("R1 testMode", testMode, 0);
    check("R1 porOvr", porOvr, 0);

    // R2, R3: all values at 00h; bits 7/5/3 kept, others read 0
    for (int v = 0; v < 256; v++) begin
      wr(8'h00, 8'(v));
      rd(8'h00, 8'(v) & 8'hA8, "R2 R3 ctl1 readback");
      check("R2 testMode", testMode, (v >> 7) & 1);
      check("R2 porOvr", porOvr, (v >> 3) & 1);
    end
    wr(8'h00, 8'h00);

    // R4, R3: all values at 01h with flags clear (writing 1 never sets a flag)
    for (int v = 0; v < 256; v++) begin
      wr(8'h01, 8'(v));
      rd(8'h01, 8'(v) & 8'h13, "R4 R3 ctl2 readback");
    end

    // R3: other addresses read 0 and change nothing
    wr(8'h00, 8'hA8);
    wr(8'h01, 8'h13);
    for (int a = 2; a < 256; a++) begin
      wr(8'(a), 8'hFF);
      rd(8'(a), 8'h00, "R3 unmapped read");
    end
    rd(8'h00, 8'hA8, "R3 ctl1 untouched");
    rd(8'h01, 8'h13, "R3 ctl2 untouched");
    wr(8'h00, 8'h00);
    wr(8'h01, 8'h00);

    // R5: flags set by events, cleared only by written 0
    for (int s = 0; s < 4; s++) begin
      for (int w = 0; w < 4; w++) begin
        wr(8'h01, 8'h00);
        if (s & 2) pulseAlarm();
        if (s & 1) pulseTimer();
        rd(8'h01, 8'((s & 2) << 2 | (s & 1) << 2), "R5 flags set");
        wr(8'h01, 8'(w << 2));
        rd(8'h01, 8'(((s & w) & 2) << 2 | ((s & w) & 1) << 2), "R5 flag clear");
      end
    end

    // R6: event and clearing write on the same edge
    wr(8'h01, 8'h00);
    pulseTimer();
    addr = 8'h01; wrData = 8'h00; wrEn = 1'b1; alarmEvt = 1'b1; timerEvt = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; alarmEvt = 1'b0; timerEvt = 1'b0;
    rd(8'h01, 8'h0C, "R6 event beats clear");

    // R7, R9: sweep mode/enables/flags with pulses expired
    tick32k = 1'b1;
    for (int i = 0; i < 32; i++) begin
      int md, ae, te, af, tf;
      md = i & 1; ae = (i >> 1) & 1; te = (i >> 2) & 1; af = (i >> 3) & 1; tf = (i >> 4) & 1;
      wr(8'h01, 8'h00);
      if (af) pulseAlarm();
      if (tf) pulseTimer();
      repeat (PL + 3) @(negedge clk);
      wr(8'h01, 8'((md << 4) | 8'h0C | (ae << 1) | te));
      rd(8'h01, 8'((md << 4) | (af << 3) | (tf << 2) | (ae << 1) | te), "R7 R9 sweep readback");
      check("R7 R9 intN", intN, ((af & ae) | (!md & tf & te)) ? 0 : 1);
    end

    // R8: pulse width and restart
    wr(8'h01, 8'h11);
    pulseTimer();
    cnt = 0;
    for (int k = 0; k < 3 * PL; k++) begin
      if (!intN) cnt++;
      @(negedge clk);
    end
    check("R8 pulse width", cnt, PL);
    pulseTimer();
    repeat (2) @(negedge clk);
    pulseTimer();
    cnt = 0;
    for (int k = 0; k < 3 * PL; k++) begin
      if (!intN) cnt++;
      @(negedge clk);
    end
    check("R8 restarted pulse tail", cnt, PL);
    wr(8'h01, 8'h10);
    pulseTimer();
    cnt = 0;
    for (int k = 0; k < 2 * PL; k++) begin
      if (!intN) cnt++;
      @(negedge clk);
    end
    check("R8 disabled timer no pulse", cnt, 0);
    wr(8'h01, 8'h00);

    // R10: periodic tick
    wr(8'h00, 8'h20);
    wr(8'h00, 8'h00);
    cnt = 0;
    for (int k = 0; k < 4 * (1 << PW); k++) begin
      if (secTick) cnt++;
      @(negedge clk);
    end
    check("R10 ticks per window", cnt, 4);

    // R11, R12: stop holds prescaler, clock output keeps going
    tick32k = 1'b1;
    repeat (7) @(negedge clk);
    wr(8'h00, 8'h20);
    cnt = 0;
    for (int k = 0; k < 40; k++) begin
      tick32k = k[0];
      #1;
      if (secTick) cnt++;
      check("R12 clkOut follows", clkOut, k[0]);
      @(negedge clk);
    end
    check("R11 no tick while stopped", cnt, 0);
    tick32k = 1'b1;
    wr(8'h00, 8'h00);
    first = 0;
    for (int k = 1; k <= 40; k++) begin
      if (secTick && first == 0) first = k;
      @(negedge clk);
    end
    check("R11 first tick after release", first, 1 << PW);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

endmodule